// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry

A purely combinational shifter for a 32-bit execution datapath where the shift distance comes from a general register, not from an instruction field. It accepts an operand, the full amount register, a 2-bit shift kind and the current carry flag. It returns the shifted operand, the carry that follows from it, and a strobe telling the flag logic whether that carry is new.

Only the least significant byte of the amount register matters. Distances from 0 up to 255 therefore reach the block. Distances of zero, exactly the word width, and beyond the word width each get their own defined result and carry. Storing flags and decoding immediate-form shifts are left to the surrounding pipeline.

Top module: `bshift_reg_carry`

## Requirements
- R1: Only amount bits [7:0] are used. Bits [31:8] of the amount register have no effect on any output.
- R2: When the amount byte is 0, for every kind, the operand passes through unchanged, the carry output equals the carry input, and the carry-updated strobe is 0.
- R3: Kind 2'b00 (shift left, zero fill) with amount n in 1..31 gives operand << n and carry = operand bit (32-n).
- R4: Kind 2'b00 with amount 32 gives 0 and carry = operand bit 0. With amount 33..255 it gives 0 and carry 0.
- R5: Kind 2'b01 (shift right, zero fill) with amount n in 1..31 gives operand >> n and carry = operand bit (n-1).
- R6: Kind 2'b01 with amount 32 gives 0 and carry = operand bit 31. With amount 33..255 it gives 0 and carry 0.
- R7: Kind 2'b10 (shift right, sign fill) with amount n in 1..31 gives the sign-extended operand >> n and carry = operand bit (n-1).
- R8: Kind 2'b10 with amount 32..255 gives 32 copies of operand bit 31 and carry = operand bit 31.
- R9: Kind 2'b11 (rotate right) with m = amount mod 32 nonzero gives the operand rotated right by m and carry = operand bit (m-1).
- R10: Kind 2'b11 with a nonzero amount that is a multiple of 32 leaves the operand unchanged and gives carry = operand bit 31.
- R11: The carry-updated strobe is 1 exactly when the amount byte is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| shiftIn | input | 32 | Operand to shift |
| amountReg | input | 32 | Register holding the shift distance; only its low byte is used |
| shiftKind | input | 2 | 00 left, 01 right logical, 10 right arithmetic, 11 rotate right |
| carryIn | input | 1 | Current carry flag |
| shiftOut | output | 32 | Shifted operand |
| carryOut | output | 1 | Next carry flag |
| carryUpdated | output | 1 | High when carryOut is a freshly produced value |

## Verification
The block holds no state, so a wrong control strobe or a wrong barrel stage shows on shiftOut or carryOut for the same input vector, with no delay. A misdecoded boundary, such as 32 treated like 33 or a rotate multiple of 32 treated like zero, shows only at those exact amounts. For that reason every amount from 0 to 255 is swept for each kind, over operands whose bit 0, bit 31 and inner bits all differ.

// File: rtl/bshift_pkg.sv
package bshift_pkg;

  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_ROR = 2'b11
  } shiftKind_e;

  typedef enum logic [2:0] {
    CSEL_KEEP  = 3'd0,
    CSEL_LSB   = 3'd1,
    CSEL_MSB   = 3'd2,
    CSEL_ZERO  = 3'd3,
    CSEL_INDEX = 3'd4
  } carrySel_e;

  typedef struct packed {
    logic      mirror;
    logic      rotate;
    logic      fillSign;
    logic      forceZero;
    logic      forceSign;
    logic      passThru;
    carrySel_e carrySel;
  } shiftStrobes_t;

endpackage

// File: rtl/bshift_ctrl.sv
module bshift_ctrl
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [REG_W-1:0] amountReg,
  input  shiftKind_e       kind,
  output shiftStrobes_t    strobes,
  output logic [LOG_W-1:0] effAmt,
  output logic             carryUpdated
);

  logic [AMT_W-1:0] amtByte;
  logic isZero, isExact, isOver, wrapZero;

  assign amtByte  = amountReg[AMT_W-1:0];
  assign isZero   = (amtByte == '0);
  assign isExact  = (amtByte == AMT_W'(WIDTH));
  assign isOver   = (amtByte > AMT_W'(WIDTH));
  assign wrapZero = (amtByte[LOG_W-1:0] == '0);
  assign effAmt   = amtByte[LOG_W-1:0];
  assign carryUpdated = |amtByte;

  always_comb begin
    strobes = '{mirror: 1'b0, rotate: 1'b0, fillSign: 1'b0, forceZero: 1'b0,
                forceSign: 1'b0, passThru: 1'b0, carrySel: CSEL_KEEP};
    if (isZero) begin
      strobes.passThru = 1'b1;
    end else begin
      unique case (kind)
        KIND_LSL: begin
          strobes.mirror = 1'b1;
          if (isExact) begin
            strobes.forceZero = 1'b1;
            strobes.carrySel  = CSEL_LSB;
          end else if (isOver) begin
            strobes.forceZero = 1'b1;
            strobes.carrySel  = CSEL_ZERO;
          end else begin
            strobes.carrySel  = CSEL_INDEX;
          end
        end
        KIND_LSR: begin
          if (isExact) begin
            strobes.forceZero = 1'b1;
            strobes.carrySel  = CSEL_MSB;
          end else if (isOver) begin
            strobes.forceZero = 1'b1;
            strobes.carrySel  = CSEL_ZERO;
          end else begin
            strobes.carrySel  = CSEL_INDEX;
          end
        end
        KIND_ASR: begin
          strobes.fillSign = 1'b1;
          if (isExact || isOver) begin
            strobes.forceSign = 1'b1;
            strobes.carrySel  = CSEL_MSB;
          end else begin
            strobes.carrySel  = CSEL_INDEX;
          end
        end
        default: begin
          strobes.rotate = 1'b1;
          if (wrapZero) begin
            strobes.passThru = 1'b1;
            strobes.carrySel = CSEL_MSB;
          end else begin
            strobes.carrySel = CSEL_INDEX;
          end
        end
      endcase
    end
  end

  always_comb begin
    a_r11_upd_matches_sel: assert (carryUpdated == (strobes.carrySel != CSEL_KEEP))
      else $error("carry strobe disagrees with carry source");
    a_r2_single_override: assert ($onehot0({strobes.passThru, strobes.forceZero, strobes.forceSign}))
      else $error("more than one result override active");
  end

endmodule

// File: rtl/bshift_dpath.sv
module bshift_dpath
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] shiftIn,
  input  logic [LOG_W-1:0] effAmt,
  input  shiftStrobes_t    strobes,
  input  logic             carryIn,
  output logic [WIDTH-1:0] shiftOut,
  output logic             carryOut
);

  logic [WIDTH-1:0] revIn, srcVec, revOut, unmirrored;
  logic [LOG_W:0][WIDTH-1:0] stg;
  logic fillBit;

  for (genvar i = 0; i < WIDTH; i++) begin : g_rev
    assign revIn[i]  = shiftIn[WIDTH-1-i];
    assign revOut[i] = stg[LOG_W][WIDTH-1-i];
  end

  assign srcVec  = strobes.mirror ? revIn : shiftIn;
  assign fillBit = strobes.fillSign & shiftIn[WIDTH-1];
  assign stg[0]  = srcVec;

  for (genvar s = 0; s < LOG_W; s++) begin : g_stage
    localparam int DIST = 1 << s;
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      if (i + DIST < WIDTH) begin : g_in
        assign stg[s+1][i] = effAmt[s] ? stg[s][i+DIST] : stg[s][i];
      end else begin : g_edge
        assign stg[s+1][i] = effAmt[s] ? (strobes.rotate ? stg[s][i+DIST-WIDTH] : fillBit)
                                       : stg[s][i];
      end
    end
  end

  assign unmirrored = strobes.mirror ? revOut : stg[LOG_W];

  always_comb begin
    if (strobes.passThru)       shiftOut = shiftIn;
    else if (strobes.forceZero) shiftOut = '0;
    else if (strobes.forceSign) shiftOut = {WIDTH{shiftIn[WIDTH-1]}};
    else                        shiftOut = unmirrored;
  end

  always_comb begin
    unique case (strobes.carrySel)
      CSEL_LSB:   carryOut = shiftIn[0];
      CSEL_MSB:   carryOut = shiftIn[WIDTH-1];
      CSEL_ZERO:  carryOut = 1'b0;
      CSEL_INDEX: carryOut = srcVec[effAmt - 1'b1];
      default:    carryOut = carryIn;
    endcase
  end

  always_comb begin
    a_r8_sign_fill_uniform: assert (!strobes.forceSign || shiftOut == '0 || shiftOut == '1)
      else $error("sign-filled result not uniform");
  end

endmodule

// File: rtl/bshift_reg_carry.sv
module bshift_reg_carry
  import bshift_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int REG_W = 32,
  parameter int AMT_W = 8,
  localparam int LOG_W = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] shiftIn,
  input  logic [REG_W-1:0] amountReg,
  input  logic [1:0]       shiftKind,
  input  logic             carryIn,
  output logic [WIDTH-1:0] shiftOut,
  output logic             carryOut,
  output logic             carryUpdated
);

  shiftStrobes_t    strobes;
  logic [LOG_W-1:0] effAmt;
  logic [AMT_W-1:0] amtByte;

  assign amtByte = amountReg[AMT_W-1:0];

  bshift_ctrl #(.WIDTH(WIDTH), .REG_W(REG_W), .AMT_W(AMT_W)) u_ctrl (
    .amountReg    (amountReg),
    .kind         (shiftKind_e'(shiftKind)),
    .strobes      (strobes),
    .effAmt       (effAmt),
    .carryUpdated (carryUpdated)
  );

  bshift_dpath #(.WIDTH(WIDTH)) u_dpath (
    .shiftIn  (shiftIn),
    .effAmt   (effAmt),
    .strobes  (strobes),
    .carryIn  (carryIn),
    .shiftOut (shiftOut),
    .carryOut (carryOut)
  );

  logic inRange;
  assign inRange = (amtByte != '0) && (amtByte < AMT_W'(WIDTH));

  always_comb begin
    a_r2_zero_hold: assert (amtByte != '0 || (shiftOut == shiftIn && carryOut == carryIn))
      else $error("zero amount altered operand or carry");
    a_r3_lsl_match: assert (!(inRange && shiftKind == 2'b00) || shiftOut == (shiftIn << amtByte))
      else $error("left shift result mismatch");
    a_r5_lsr_match: assert (!(inRange && shiftKind == 2'b01) || shiftOut == (shiftIn >> amtByte))
      else $error("logical right result mismatch");
    a_r7_asr_match: assert (!(inRange && shiftKind == 2'b10)
                            || shiftOut == WIDTH'($signed(shiftIn) >>> amtByte))
      else $error("arithmetic right result mismatch");
    a_r9_ror_match: assert (!(shiftKind == 2'b11 && amtByte[LOG_W-1:0] != '0)
                            || shiftOut == ((shiftIn >> amtByte[LOG_W-1:0])
                                          | (shiftIn << (WIDTH - int'(amtByte[LOG_W-1:0])))))
      else $error("rotate result mismatch");
  end

endmodule

// File: tb/test_bshift_reg_carry.sv
module test_bshift_reg_carry;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] shiftIn = '0;
  logic [31:0] amountReg = '0;
  logic [1:0]  shiftKind = '0;
  logic        carryIn = 1'b0;
  logic [31:0] shiftOut;
  logic        carryOut, carryUpdated;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  bshift_reg_carry i_bshift_reg_carry (
    .shiftIn(shiftIn), .amountReg(amountReg), .shiftKind(shiftKind),
    .carryIn(carryIn), .shiftOut(shiftOut), .carryOut(carryOut),
    .carryUpdated(carryUpdated)
  );

  function automatic string reqTag(input int k, input int n);
    if (n == 0) return "R2";
    case (k)
      0: return (n < 32) ? "R3" : "R4";
      1: return (n < 32) ? "R5" : "R6";
      2: return (n < 32) ? "R7" : "R8";
      default: return (n % 32 != 0) ? "R9" : "R10";
    endcase
  endfunction

  task automatic applyCheck(input logic [31:0] v, input int k, input int n,
                            input logic [23:0] hi, input logic cin);
    logic [31:0] expV;
    logic expC, expU;
    int m;
    string tag;
    @(negedge clk);
    shiftIn = v; shiftKind = 2'(k); amountReg = {hi, 8'(n)}; carryIn = cin;
    expV = v; expC = cin; expU = (n != 0);
    if (n != 0) begin
      case (k)
        0: if (n < 32) begin expV = v << n; expC = v[32-n]; end
           else begin expV = 0; expC = (n == 32) ? v[0] : 1'b0; end
        1: if (n < 32) begin expV = v >> n; expC = v[n-1]; end
           else begin expV = 0; expC = (n == 32) ? v[31] : 1'b0; end
        2: if (n < 32) begin
             expV = v >> n;
             if (v[31]) expV = expV | ~(32'hFFFF_FFFF >> n);
             expC = v[n-1];
           end else begin expV = {32{v[31]}}; expC = v[31]; end
        default: begin
          m = n % 32;
          if (m == 0) begin expV = v; expC = v[31]; end
          else begin expV = (v >> m) | (v << (32 - m)); expC = v[m-1]; end
        end
      endcase
    end
    tag = reqTag(k, n);
    if (hi != 0) tag = {tag, "/R1"};
    #5;
    nVec++;
    if (shiftOut !== expV || carryOut !== expC || carryUpdated !== expU) begin
      nBad++;
      $display("FAIL %s/R11 kind=%0d amt=%0d hi=%h in=%h: got %h c%b u%b expected %h c%b u%b",
               tag, k, n, hi, v, shiftOut, carryOut, carryUpdated, expV, expC, expU);
    end
  endtask

  initial begin : watchdog
    #3_000_000;
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin : stim
    logic [31:0] pats [6];
    pats[0] = 32'h8000_0001; pats[1] = 32'h7FFF_FFFE; pats[2] = 32'hA5C3_0F96;
    pats[3] = 32'hFFFF_FFFF; pats[4] = 32'h0000_0000; pats[5] = 32'h1234_5678;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // R2: idle inputs after reset leave all outputs low
    @(negedge clk); #5;
    nVec++;
    if (shiftOut !== 0 || carryOut !== 0 || carryUpdated !== 0) begin
      nBad++;
      $display("FAIL R2 reset state: got %h c%b u%b expected 0 c0 u0",
               shiftOut, carryOut, carryUpdated);
    end
    for (int k = 0; k < 4; k++)
      for (int n = 0; n < 256; n++)
        for (int p = 0; p < 6; p++) begin
          applyCheck(pats[p], k, n, 24'h0, 1'(p));
          // R1: upper amount bits set must not change anything
          applyCheck(pats[p], k, n, 24'(32'h5A3C1 * (n + 1) + p), ~1'(p));
        end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

endmodule